// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block sits on the host side of a three-wire link to a 12-bit successive-approximation converter. The link carries an active-low chip select, a serial clock and a serial data input. A frame begins when a one-cycle start pulse arrives, or when the free-running sample timer expires while automatic sampling is enabled. Chip select then falls, and the block produces exactly twenty serial-clock periods. It samples the data line on each rising serial-clock edge and places the twelve bits that fall inside a configurable window into a straight-binary result, which it publishes with a one-cycle valid strobe. After each frame it holds chip select high for a minimum quiet gap. A request that arrives while the link is busy is kept and served as soon as the gap allows.

All timing derives from the system clock. The parameters give the serial-clock half period, the quiet gap, the sample period and the wake-up wait, each counted in system-clock cycles. The defaults suit a 100 MHz system clock: a 10 MHz serial clock, a 50 ns gap and a 1 us wake wait. A power-down level request makes the block issue a truncated frame that puts the converter to sleep. When the request is withdrawn, the block runs one discarded wake-up frame and then waits out the wake-up time before it serves any further frame.

Top module: `adc_cap_ctrl`

## Requirements
- R1: After reset, cs_n and sclk are 1, sample_valid is 0 and sample is 0.
- R2: cs_n falls only while sclk is 1. The first falling sclk edge comes exactly HALF_DIV system cycles after cs_n falls.
- R3: While cs_n is low, every sclk low phase and every sclk high phase lasts exactly HALF_DIV system cycles, including the final high phase before cs_n rises.
- R4: A normal frame contains exactly FRAME_CLKS (20) rising sclk edges, and cs_n rises at the end of the last high phase.
- R5: sdata is sampled at each rising sclk edge, with edges numbered 0 to 19 within the frame. The sample at edge FIRST_BIT + j becomes result bit DATA_W-1-j, so the result is MSB first. Samples at edges outside FIRST_BIT..FIRST_BIT+DATA_W-1 do not affect the result.
- R6: sample_valid is high for exactly one system cycle, the first cycle in which cs_n is high after a normal frame. sample carries that frame's result and is never asserted while cs_n is low.
- R7: Between frames, cs_n stays high for at least QUIET_CYC system cycles.
- R8: A start pulse received while a frame or quiet gap is in progress is held. The next frame then starts with cs_n high for exactly QUIET_CYC cycles.
- R9: With auto_en held at 1 and frames shorter than the period, successive falling edges of cs_n are exactly TIMER_CYC system cycles apart.
- R10: When pd_req rises while the block is idle, it issues one frame of PD_CLKS rising edges with no sample_valid, then holds cs_n high. Start pulses received while powered down are discarded.
- R11: When pd_req falls, the block issues one full wake-up frame without sample_valid, then keeps cs_n high for at least WAKE_CYC cycles. A request held during that frame is served with cs_n high for exactly WAKE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request for a conversion frame |
| auto_en | input | 1 | Enables the free-running sample timer |
| pd_req | input | 1 | Level request to keep the converter powered down |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sample | output | DATA_W | Last captured straight-binary result |
| sample_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest situations to reach from the ports are a request that is held across the wake-up interval and a start pulse that arrives while the converter sleeps. Both depend on when the stimulus lands relative to internal phases that the ports do not show. The bench brings them about by raising pd_req and waiting out the truncated frame. It then pulses start while asleep, drops pd_req, and pulses start again during the wake-up frame. It checks that cs_n stays high for exactly the wake time and that exactly two frames follow. A behavioural converter model drives bit patterns outside the capture window so that any leakage into the result appears, and a start pulse timed to the first quiet cycle exercises the pending path.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_QUIET,
    ST_PDWN,
    ST_WAKE
  } cap_state_e;

  typedef enum logic [1:0] {
    FR_NORMAL,
    FR_SHORT,
    FR_DUMMY
  } frame_kind_e;

endpackage

// File: rtl/adc_cap_timer.sv
module adc_cap_timer #(
  parameter int TIMER_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (TIMER_CYC > 2) ? $clog2(TIMER_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMER_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (!en)              cnt_nx = '0;
    else if (cnt_q == LAST) cnt_nx = '0;
    else                  cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign tick = en && (cnt_q == LAST);

  assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adc_cap_shift.sv
module adc_cap_shift #(
  parameter int DATA_W     = 12,
  parameter int FIRST_BIT  = 4,
  parameter int BIT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_en,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              sdata,
  output logic [DATA_W-1:0] word
);
  localparam logic [BIT_W:0] WIN_LO = (BIT_W+1)'(FIRST_BIT);
  localparam logic [BIT_W:0] WIN_HI = (BIT_W+1)'(FIRST_BIT + DATA_W);

  logic [DATA_W-1:0] sh_q, sh_nx;
  logic              in_win;

  assign in_win = ({1'b0, bit_idx} >= WIN_LO) && ({1'b0, bit_idx} < WIN_HI);

  always_comb begin
    sh_nx = sh_q;
    if (clr)                  sh_nx = '0;
    else if (cap_en && in_win) sh_nx = {sh_q[DATA_W-2:0], sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nx;
  end

  assign word = sh_q;

  // R5: captures outside the window leave the register untouched
  assert_window_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !in_win && !clr) |=> $stable(sh_q));

endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int FRAME_CLKS = 20,
  parameter int FIRST_BIT  = 4,
  parameter int HALF_DIV   = 5,
  parameter int QUIET_CYC  = 5,
  parameter int TIMER_CYC  = 250,
  parameter int PD_CLKS    = 3,
  parameter int WAKE_CYC   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              auto_en,
  input  logic              pd_req,
  input  logic              sdata,
  output logic              cs_n,
  output logic              sclk,
  output logic [DATA_W-1:0] sample,
  output logic              sample_valid
);
  localparam int BIT_W  = $clog2(FRAME_CLKS);
  localparam int MAXCNT = (HALF_DIV > QUIET_CYC) ?
                          ((HALF_DIV > WAKE_CYC) ? HALF_DIV : WAKE_CYC) :
                          ((QUIET_CYC > WAKE_CYC) ? QUIET_CYC : WAKE_CYC);
  localparam int CNT_W  = $clog2(MAXCNT + 1);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] QUIET_LD = CNT_W'(QUIET_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_FULL  = BIT_W'(FRAME_CLKS - 1);
  localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(PD_CLKS - 1);

  // reset: asserted asynchronously, released on the clock
  logic rs0_q, rs1_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_i = rs1_q;

  cap_state_e        st_q, st_nx;
  frame_kind_e       kind_q, kind_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [BIT_W-1:0]  bit_q, bit_nx;
  logic              pend_q, pend_nx;
  logic              cs_q, sclk_q, vld_q;
  logic [DATA_W-1:0] smp_q;
  logic              tick, clr, cap_en, end_nrm;
  logic [DATA_W-1:0] word;
  logic [BIT_W-1:0]  last_bit;

  adc_cap_timer #(.TIMER_CYC(TIMER_CYC)) u_timer (
    .clk(clk), .rst_n(rst_i), .en(auto_en), .tick(tick)
  );

  adc_cap_shift #(.DATA_W(DATA_W), .FIRST_BIT(FIRST_BIT), .BIT_W(BIT_W)) u_shift (
    .clk(clk), .rst_n(rst_i), .clr(clr), .cap_en(cap_en),
    .bit_idx(bit_q), .sdata(sdata), .word(word)
  );

  assign cap_en   = (st_q == ST_LOW) && (cnt_q == '0);
  assign last_bit = (kind_q == FR_SHORT) ? LAST_SHORT : LAST_FULL;

  always_comb begin
    st_nx   = st_q;
    kind_nx = kind_q;
    cnt_nx  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    bit_nx  = bit_q;
    pend_nx = pend_q | start | tick;
    clr     = 1'b0;
    end_nrm = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pd_req) begin
          st_nx = ST_SETUP; kind_nx = FR_SHORT; cnt_nx = HALF_LD; clr = 1'b1;
        end else if (pend_q) begin
          st_nx = ST_SETUP; kind_nx = FR_NORMAL; cnt_nx = HALF_LD; clr = 1'b1;
          pend_nx = start | tick;
        end
      end
      ST_SETUP: if (cnt_q == '0) begin
        st_nx = ST_LOW; cnt_nx = HALF_LD; bit_nx = '0;
      end
      ST_LOW: if (cnt_q == '0) begin
        st_nx = ST_HIGH; cnt_nx = HALF_LD;
      end
      ST_HIGH: if (cnt_q == '0) begin
        if (bit_q == last_bit) begin
          if (kind_q == FR_DUMMY) begin
            st_nx = ST_WAKE; cnt_nx = WAKE_LD;
          end else begin
            st_nx = ST_QUIET; cnt_nx = QUIET_LD;
            end_nrm = (kind_q == FR_NORMAL);
          end
        end else begin
          st_nx = ST_LOW; cnt_nx = HALF_LD; bit_nx = bit_q + 1'b1;
        end
      end
      ST_QUIET, ST_WAKE: if (cnt_q == '0) begin
        if (st_q == ST_QUIET && kind_q == FR_SHORT) begin
          st_nx = ST_PDWN; pend_nx = 1'b0;
        end else if (pend_q && !pd_req) begin
          st_nx = ST_SETUP; kind_nx = FR_NORMAL; cnt_nx = HALF_LD; clr = 1'b1;
          pend_nx = start | tick;
        end else begin
          st_nx = ST_IDLE;
        end
      end
      ST_PDWN: begin
        pend_nx = 1'b0;
        if (!pd_req) begin
          st_nx = ST_SETUP; kind_nx = FR_DUMMY; cnt_nx = HALF_LD; clr = 1'b1;
          pend_nx = start | tick;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_IDLE;
      kind_q <= FR_NORMAL;
      cnt_q  <= '0;
      bit_q  <= '0;
      pend_q <= 1'b0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_nx;
      kind_q <= kind_nx;
      cnt_q  <= cnt_nx;
      bit_q  <= bit_nx;
      pend_q <= pend_nx;
      cs_q   <= !((st_nx == ST_SETUP) || (st_nx == ST_LOW) || (st_nx == ST_HIGH));
      sclk_q <= (st_nx != ST_LOW);
      vld_q  <= end_nrm;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       smp_q <= '0;
    else if (end_nrm) smp_q <= word;
  end

  assign cs_n         = cs_q;
  assign sclk         = sclk_q;
  assign sample       = smp_q;
  assign sample_valid = vld_q;

  assert_cs_fall_sclk_high_R2: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(cs_q) |-> sclk_q);
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_i)
    ((st_q == ST_LOW || st_q == ST_HIGH) && cnt_q != '0) |=> $stable(sclk_q));
  assert_bit_bound_R4: assert property (@(posedge clk) disable iff (!rst_i)
    bit_q < BIT_W'(FRAME_CLKS));
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_i)
    vld_q |=> !vld_q);
  assert_valid_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_i)
    vld_q |-> (cs_q && !$past(cs_q)));
  assert_quiet_high_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_QUIET || st_q == ST_WAKE) |-> cs_q);
  assert_pdwn_idle_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_PDWN) |-> (cs_q && !vld_q && !pend_q));

endmodule

// File: tb/tb_adc_cap_ctrl.sv
module tb_adc_cap_ctrl;
  localparam int DW = 12, FR = 20, FB = 4, HALF = 2, QUIET = 4;
  localparam int TMR = 150, PDC = 3, WAKE = 24;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, auto_en = 1'b0, pd_req = 1'b0;
  logic sdata = 1'b0;
  logic cs_n, sclk, sample_valid;
  logic [DW-1:0] sample;

  adc_cap_ctrl #(.DATA_W(DW), .FRAME_CLKS(FR), .FIRST_BIT(FB), .HALF_DIV(HALF),
    .QUIET_CYC(QUIET), .TIMER_CYC(TMR), .PD_CLKS(PDC), .WAKE_CYC(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_en(auto_en), .pd_req(pd_req),
    .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .sample(sample), .sample_valid(sample_valid));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural converter: bit k is driven on the k-th falling sclk edge
  logic [DW-1:0] model_val = '0, frame_val = '0;
  int fcnt = 0;
  always @(negedge cs_n) begin frame_val = model_val; fcnt = 0; end
  always @(negedge sclk) if (!cs_n) begin
    if (fcnt >= FB && fcnt < FB + DW) sdata = frame_val[DW-1-(fcnt-FB)];
    else                              sdata = ~(fcnt[0] ^ frame_val[0]);
    fcnt++;
  end

  // port monitor
  bit mon_on = 0, prev_cs = 1, prev_sclk = 1, chk_period = 0, wake_gap_chk = 0;
  int hi_cnt = 1000, ph_cnt = 0, rises = 0, falls = 0, last_fall = -1, exp_gap = -1;
  int cur_kind = 0, next_kind = 0;
  always @(negedge clk) if (mon_on) begin
    if (prev_cs && !cs_n) begin
      chk(sclk == 1'b1, "R2 cs falls with sclk high", sclk, 1);
      chk(hi_cnt >= QUIET, "R7 quiet gap", hi_cnt, QUIET);
      if (exp_gap >= 0) begin
        chk(hi_cnt == exp_gap, "R8/R11 held request gap", hi_cnt, exp_gap);
        exp_gap = -1;
      end
      if (chk_period && last_fall >= 0)
        chk(cyc - last_fall == TMR, "R9 timer period", cyc - last_fall, TMR);
      last_fall = cyc;
      falls++;
      cur_kind = next_kind;
      next_kind = (next_kind == 1) ? 2 : 0;
      rises = 0; ph_cnt = 1;
    end else if (!cs_n) begin
      if (sclk != prev_sclk) begin
        chk(ph_cnt == HALF, "R2/R3 phase length", ph_cnt, HALF);
        if (sclk) rises++;
        ph_cnt = 1;
      end else ph_cnt++;
      chk(!sample_valid, "R6 no strobe in frame", sample_valid, 0);
    end else if (!prev_cs && cs_n) begin
      chk(ph_cnt == HALF, "R3 last high phase", ph_cnt, HALF);
      chk(rises == ((cur_kind == 1) ? PDC : FR), "R4/R10/R11 edge count",
          rises, (cur_kind == 1) ? PDC : FR);
      chk(sample_valid == (cur_kind == 0), "R6/R10/R11 strobe", sample_valid, cur_kind == 0);
      if (cur_kind == 0)
        chk(sample == frame_val, "R5 captured value", sample, frame_val);
      if (cur_kind == 2 && wake_gap_chk) begin exp_gap = WAKE; wake_gap_chk = 0; end
      hi_cnt = 1;
    end else begin
      hi_cnt++;
      chk(!sample_valid, "R6 single strobe", sample_valid, 0);
    end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    chk(sclk == 1'b1, "R1 reset sclk", sclk, 1);
    chk(sample_valid == 1'b0, "R1 reset strobe", sample_valid, 0);
    chk(sample == '0, "R1 reset sample", sample, 0);
    prev_cs = cs_n; prev_sclk = sclk; mon_on = 1;

    // R5 value sweep: walking ones, walking zeros, extremes, stepped codes
    for (int i = 0; i < 80; i++) begin
      if (i < 12)       model_val = DW'(1) << i;
      else if (i < 24)  model_val = ~(DW'(1) << (i - 12));
      else if (i == 24) model_val = '0;
      else if (i == 25) model_val = '1;
      else              model_val = DW'((i * 1237 + 91) % 4096);
      pulse_start();
      idle(100);
    end

    // R8: request during a frame
    model_val = 12'hA5C; pulse_start(); idle(30);
    model_val = 12'h3C1; exp_gap = QUIET; pulse_start(); idle(200);
    // R8: request during the quiet gap
    model_val = 12'h7E2; pulse_start(); idle(10);
    exp_gap = QUIET; model_val = 12'h19B;
    @(posedge cs_n);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    idle(200);

    // R9: free-running timer
    model_val = 12'h555; last_fall = -1; chk_period = 1; auto_en = 1'b1;
    idle(5 * TMR + 10);
    auto_en = 1'b0; chk_period = 0; idle(200);

    // R10: power-down entry, start ignored while asleep
    next_kind = 1; pd_req = 1'b1; idle(80);
    begin
      int f0;
      f0 = falls;
      pulse_start(); idle(60);
      chk(falls == f0, "R10 start ignored asleep", falls - f0, 0);
      chk(cs_n == 1'b1, "R10 cs held high asleep", cs_n, 1);
      // R11: wake frame, then held request after the wake wait
      model_val = 12'hC3A; wake_gap_chk = 1; pd_req = 1'b0; idle(3);
      pulse_start(); idle(250);
      chk(falls == f0 + 2, "R11 frames after wake", falls - f0, 2);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule